// File: doc/BRIEF.md
# Paged Write Commit Engine for a Serial Memory

This block sits behind a two-wire slave front end and in front of a 512-byte storage array. The front end opens a write with a 9-bit word address and then hands over data bytes one at a time. The block gathers these bytes in a 16-entry page buffer. Each entry also has a valid bit.

Each byte goes to the buffer slot named by the low four address bits. Those bits then step forward and wrap inside the page, while the page row stays fixed. When the front end reports the stop that ends the sequence, the block checks the write-protect rule. If the rule allows it, the block copies the received bytes into the array during a self-timed busy window. While that window lasts, the busy output is high and new sequences are refused, so the front end can withhold its acknowledge.

A registered read port and the exported address pointer let the front end carry out reads, including reads at the current address.

Top module: `pgw_page_writer`

## Requirements
- R1: After reset, `busy` is 0 and `cur_addr` is 0. The array holds 0 in every location.
- R2: A `wr_start` pulse while `busy` is 0 loads `cur_addr` with `wr_addr` on the next clock edge. It also clears every slot's valid bit.
- R3: Each accepted byte is stored at slot `cur_addr[3:0]`. After it, `cur_addr[3:0]` increments by one and `cur_addr[8:4]` keeps its value.
- R4: After slot 15 the next byte goes to slot 0 of the same page. If more than 16 bytes are sent, the later bytes replace the earlier ones.
- R5: Commit changes only the slots that received a byte in the current sequence. All other locations keep their old contents.
- R6: The array is not changed before the stop. A read of a targeted address before the stop returns the old value.
- R7: After a stop that commits, `busy` rises on the next clock edge and stays high for exactly `BUSY_CYCLES` cycles. The array is written only while `busy` is high.
- R8: While `busy` is high, `wr_start`, `byte_valid` and `stop` have no effect. `cur_addr` does not change, and no address outside the page being committed is written.
- R9: With `wp` = 1, a sequence aimed at word addresses 256 to 511 (`wr_addr[8]` = 1) is dropped at the stop. No busy window starts and the array is unchanged. With `wp` = 1, addresses 0 to 255 commit normally, and with `wp` = 0 every address commits.
- R10: A stop after a sequence that carried no data bytes starts no busy window.
- R11: `rd_data` shows the array content at the `rd_addr` value sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Opens a write sequence at `wr_addr` |
| wr_addr | input | 9 | Word address for the new sequence |
| byte_valid | input | 1 | A data byte is presented |
| byte_data | input | 8 | Data byte |
| stop | input | 1 | Ends the current write sequence |
| wp | input | 1 | Write protect for the upper half of the array |
| rd_addr | input | 9 | Read word address |
| rd_data | output | 8 | Read data, one cycle after `rd_addr` |
| busy | output | 1 | Commit window in progress |
| cur_addr | output | 9 | Shared address pointer |

## Verification
The bench builds the block with `BUSY_CYCLES` = 20 and keeps the 9-bit address and 4-bit page defaults. With this setting the whole busy window can be counted edge by edge, and every commit is followed by a read-back of all 16 slots of its page. Because the page size and array size are the real ones, the wrap at slot 15, the overrun past 16 bytes and the protect boundary at address 256 are all exercised at their true positions.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic {PH_IDLE, PH_FILL} phase_e;

  // A commit is refused when protection is on and the row lies in the upper half.
  function automatic logic commit_blocked(input logic prot, input logic upper_half);
    return prot && upper_half;
  endfunction

  // Next slot inside a page; wraps by the natural width of the slot index.
  function automatic logic [3:0] slot_after(input logic [3:0] slot);
    return slot + 4'd1;
  endfunction
endpackage

// File: rtl/pgw_page_buffer.sv
module pgw_page_buffer #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    wr_en,
  input  logic [PAGE_W-1:0]       wr_slot,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [PAGE_W-1:0]       rd_slot,
  output logic [DATA_W-1:0]       rd_data,
  output logic [(1<<PAGE_W)-1:0]  mask
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] slot_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[s] <= '0;
        mask[s]   <= 1'b0;
      end else if (clear) begin
        mask[s]   <= 1'b0;
      end else if (wr_en && wr_slot == PAGE_W'(s)) begin
        slot_q[s] <= wr_data;
        mask[s]   <= 1'b1;
      end
    end
  end

  assign rd_data = slot_q[rd_slot];
endmodule

// File: rtl/pgw_commit_timer.sv
module pgw_commit_timer #(
  parameter int BUSY_CYCLES = 250000,
  parameter int PAGE_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              busy,
  output logic              slot_vld,
  output logic [PAGE_W-1:0] slot
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam int SLOTS = 1 << PAGE_W;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (go) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (cnt == CNT_W'(BUSY_CYCLES - 1)) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // The first SLOTS cycles of the window sweep the page buffer.
  assign slot_vld = busy && (cnt < CNT_W'(SLOTS));
  assign slot     = cnt[PAGE_W-1:0];
endmodule

// File: rtl/pgw_sram.sv
module pgw_sram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgw_page_writer.sv
module pgw_page_writer #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 4,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop,
  input  logic              wp,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr
);
  import pgw_pkg::*;

  localparam int ROW_W = ADDR_W - PAGE_W;
  localparam int SLOTS = 1 << PAGE_W;

  phase_e              phase;
  logic [ROW_W-1:0]    row;
  logic [PAGE_W-1:0]   low;
  logic [SLOTS-1:0]    mask;
  logic [DATA_W-1:0]   buf_data;
  logic                slot_vld;
  logic [PAGE_W-1:0]   slot;

  // Named internal events, also observed by the bound checker.
  logic take_start, accept_byte, end_seq, commit_go, mem_we, row_msb;

  assign row_msb     = row[ROW_W-1];
  assign take_start  = wr_start && !busy;
  assign accept_byte = byte_valid && !wr_start && !busy && phase == PH_FILL;
  assign end_seq     = stop && !wr_start && !busy && phase == PH_FILL;
  assign commit_go   = end_seq && (|mask) && !commit_blocked(wp, row_msb);
  assign mem_we      = slot_vld && mask[slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      row   <= '0;
      low   <= '0;
    end else if (take_start) begin
      phase <= PH_FILL;
      row   <= wr_addr[ADDR_W-1:PAGE_W];
      low   <= wr_addr[PAGE_W-1:0];
    end else if (accept_byte) begin
      low   <= PAGE_W'(slot_after(4'(low)));
    end else if (end_seq) begin
      phase <= PH_IDLE;
    end
  end

  assign cur_addr = {row, low};

  pgw_page_buffer #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) buf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (take_start),
    .wr_en   (accept_byte),
    .wr_slot (low),
    .wr_data (byte_data),
    .rd_slot (slot),
    .rd_data (buf_data),
    .mask    (mask)
  );

  pgw_commit_timer #(.BUSY_CYCLES(BUSY_CYCLES), .PAGE_W(PAGE_W)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (commit_go),
    .busy     (busy),
    .slot_vld (slot_vld),
    .slot     (slot)
  );

  pgw_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ram_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr ({row, slot}),
    .wdata (buf_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 4,
  parameter int BUSY_CYCLES = 250000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wr_start,
  input logic              wp,
  input logic              row_msb,
  input logic              accept_byte,
  input logic              mem_we,
  input logic [ADDR_W-1:0] cur_addr
);
  localparam int RUN_W = $clog2(BUSY_CYCLES + 1);

  logic [RUN_W-1:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) run <= '0;
    else                 run <= run + 1'b1;
  end

  assert_array_write_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_window_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < RUN_W'(BUSY_CYCLES));

  assert_no_commit_when_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp && row_msb));

  assert_row_kept_on_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_byte |=> (cur_addr[ADDR_W-1:PAGE_W] == $past(cur_addr[ADDR_W-1:PAGE_W]))
      && (cur_addr[PAGE_W-1:0] == PAGE_W'($past(cur_addr[PAGE_W-1:0]) + 1'b1)));

  assert_start_refused_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_start) |=> $stable(cur_addr));

  assert_no_byte_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_byte |-> !busy);
endmodule

bind pgw_page_writer pgw_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .wr_start    (wr_start),
  .wp          (wp),
  .row_msb     (row_msb),
  .accept_byte (accept_byte),
  .mem_we      (mem_we),
  .cur_addr    (cur_addr)
);

// File: tb/pgw_page_writer_tb.sv
module pgw_page_writer_tb_top;
  localparam int BUSY = 20;
  localparam int NV   = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_start = 1'b0, byte_valid = 1'b0, stop = 1'b0, wp = 1'b0;
  logic [8:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] byte_data = '0;
  logic [7:0] rd_data;
  logic       busy;
  logic [8:0] cur_addr;

  int checks = 0;
  int fails  = 0;
  logic [7:0] shadow [512];

  always #10 clk = ~clk;

  pgw_page_writer #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .stop(stop), .wp(wp),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .cur_addr(cur_addr)
  );

  // vector: {start address[22:14], byte count[13:9], wp[8], first data[7:0]}
  localparam logic [22:0] VEC [NV] = '{
    {9'h000, 5'd16, 1'b0, 8'h10},   // full page, R3 R5
    {9'h01D, 5'd5,  1'b0, 8'h40},   // crosses slot 15, R4
    {9'h02F, 5'd17, 1'b0, 8'h80},   // overrun by one, R4
    {9'h1A3, 5'd3,  1'b1, 8'hC0},   // upper half locked, R9
    {9'h0F6, 5'd4,  1'b1, 8'hE0},   // lower half while locked, R9
    {9'h1A3, 5'd3,  1'b0, 8'h55},   // upper half unlocked, R9
    {9'h020, 5'd0,  1'b0, 8'h00}    // no data bytes, R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic read_chk(input string req, input logic [8:0] a);
    rd_addr = a;
    @(negedge clk);
    check(req, 32'(rd_data), 32'(shadow[a]));
  endtask

  task automatic run_seq(input logic [8:0] a, input int n, input logic w, input logic [7:0] seed);
    bit commits;
    int len;
    commits = (n > 0) && !(w && a[8]);
    wp = w;
    wr_addr = a; wr_start = 1'b1;
    @(negedge clk);
    wr_start = 1'b0;
    check("R2 pointer load", 32'(cur_addr), 32'(a));
    for (int i = 0; i < n; i++) begin
      byte_valid = 1'b1; byte_data = 8'(seed + i);
      @(negedge clk);
    end
    byte_valid = 1'b0;
    check("R3 R4 pointer after bytes", 32'(cur_addr), 32'({a[8:4], 4'((a[3:0] + n) % 16)}));
    if (n > 0) read_chk("R6 array unchanged before stop", a);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check(commits ? "R7 busy after stop" : "R9 R10 no busy", 32'(busy), 32'(commits));
    if (commits) begin
      for (int i = 0; i < n; i++) shadow[{a[8:4], 4'((a[3:0] + i) % 16)}] = 8'(seed + i);
      len = 0;
      while (busy) begin len++; @(negedge clk); end
      check("R7 busy length", 32'(len), 32'(BUSY));
    end
    for (int s = 0; s < 16; s++) read_chk("R4 R5 R9 page readback", {a[8:4], 4'(s)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    for (int i = 0; i < 512; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy reset", 32'(busy), 32'd0);
    check("R1 pointer reset", 32'(cur_addr), 32'd0);
    read_chk("R1 R11 array reset", 9'h1FF);

    for (int v = 0; v < NV; v++)
      run_seq(VEC[v][22:14], int'(VEC[v][13:9]), VEC[v][8], VEC[v][7:0]);

    // R8: start and data offered inside the busy window are refused.
    wp = 1'b0;
    wr_addr = 9'h040; wr_start = 1'b1; @(negedge clk); wr_start = 1'b0;
    byte_valid = 1'b1; byte_data = 8'h33; @(negedge clk);
    byte_data = 8'h34; @(negedge clk); byte_valid = 1'b0;
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    shadow[9'h040] = 8'h33; shadow[9'h041] = 8'h34;
    check("R7 busy after stop", 32'(busy), 32'd1);
    wr_addr = 9'h150; wr_start = 1'b1; @(negedge clk); wr_start = 1'b0;
    byte_valid = 1'b1; byte_data = 8'hAA; @(negedge clk); byte_valid = 1'b0;
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    check("R8 pointer held while busy", 32'(cur_addr), 32'h042);
    while (busy) @(negedge clk);
    @(negedge clk);
    check("R8 no second window", 32'(busy), 32'd0);
    read_chk("R8 refused address untouched", 9'h150);
    read_chk("R5 committed slot 0", 9'h040);
    read_chk("R5 committed slot 1", 9'h041);
    read_chk("R5 untouched slot 2", 9'h042);
    summary();
  end
endmodule